// File: doc/BRIEF.md
# Linked-Descriptor Transmit Channel Engine

This block runs one transmit channel by walking a chain of buffer descriptors kept in memory. Each descriptor occupies four 32-bit words: at +0 the link to the following descriptor, at +4 the buffer address, at +8 the buffer length, and at +12 a mode/status word. Software builds a chain, sets the ownership flag in every mode word, enables the engine and writes the address of the first descriptor into the head register. The engine reads each owned descriptor through a valid/ready word port. It hands the buffer address and length to an external data mover and waits for the mover's done pulse. It then writes the mode word back with ownership cleared, so software can reclaim the descriptor.

After each write-back the engine loads that descriptor's address into the completion register and raises its interrupt request. Software acknowledges by writing the same address back. The end of a chain is marked in the last descriptor's mode word, after which the channel sits idle until a new head write arrives. A teardown command stops the channel at the next descriptor boundary and leaves a fixed sentinel in the completion register. A soft reset command returns the whole channel to its reset state.

Register selects on `reg_sel`: 0 head pointer, 1 completion pointer, 2 teardown command (reads 0), 3 control (bit 0 enable), 4 soft reset (bit 0).

Top module: `dma_txchan_engine`

## Requirements
- R1: After reset the head, completion, control and soft-reset registers read 0 and `irq` is 0.
- R2: With enable set, a nonzero write to the head register makes the engine read the descriptor words at +0, +4, +8 and +12, in that order.
- R3: For an owned descriptor, `mv_req` is high for exactly one cycle, with `mv_addr` equal to the word at +4 and `mv_len` equal to bits 10:0 of the word at +8. The write-back waits for `mv_done`.
- R4: The write-back stores the mode word at +12 with bit 29 (ownership) cleared and bits 31, 30 and 10:0 unchanged.
- R5: A nonzero link word makes the engine process the linked descriptor next. A zero link word sets bit 28 (end of queue) in the written-back mode word, and the head register then reads 0 with the channel idle. A later head write starts processing again.
- R6: Every write-back loads the descriptor's address into the completion register and sets `irq`.
- R7: A write to the completion register clears `irq` only when the value written equals the last address the engine loaded there. Any other value leaves `irq` set.
- R8: A head write while the channel is processing a descriptor, or while a teardown is pending, is ignored.
- R9: A descriptor whose mode bit 29 is clear gets no mover request and no write-back. The head register then reads 0 and `irq` is unchanged.
- R10: Clearing control bit 0 stops new descriptor fetches. A descriptor in progress still completes, and the head register holds the pending link. Setting the bit again resumes the walk from that link.
- R11: Writing the channel number to the teardown register while a descriptor is in progress lets that descriptor complete. Its written-back mode word also has bit 27 (teardown complete) set. The completion register becomes 0xFFFFFFFC, `irq` is set, the head register reads 0, and the rest of the chain stays untouched.
- R12: A teardown command on an idle channel loads 0xFFFFFFFC into the completion register and sets `irq` without any memory write. A value different from the channel number has no effect.
- R13: Writing 1 to the soft-reset register makes it read 1 for SRST_CYCLES cycles and then 0. During that time the memory port and mover stay quiet. Afterwards every register holds its reset value.
- R14: Once the memory port raises `mem_valid`, it keeps the request, its address and its direction unchanged until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_valid | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mv_req | output | 1 | One-cycle start pulse to the data mover |
| mv_addr | output | 32 | Buffer address for the mover |
| mv_len | output | 11 | Buffer length for the mover |
| mv_done | input | 1 | One-cycle completion pulse from the mover |
| irq | output | 1 | Completion interrupt request |

## Verification
The bound checker watches, on every cycle, that memory requests hold steady until accepted and that the mover start is a single-cycle pulse. It also checks that a fetch never begins with enable clear, that each write-back or teardown event leaves the expected completion value and raises the interrupt only for that reason, and that the ports stay quiet during soft reset. Only the bench's scenarios can show the contents of the written-back mode words, the read order of the descriptor words, the chain walk and its end-of-queue mark, the skipping of unowned descriptors, the ignored head writes, and the acknowledge rule, because these depend on the memory image and on what software writes.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int WORD_W    = 32;
    localparam int LEN_W     = 11;
    localparam int SEL_W     = 3;

    // mode word flag positions (software decodes these)
    localparam int SOP_BIT   = 31;
    localparam int EOP_BIT   = 30;
    localparam int OWN_BIT   = 29;
    localparam int EOQ_BIT   = 28;
    localparam int TDC_BIT   = 27;

    localparam logic [WORD_W-1:0] STOP_MARK = 32'hFFFF_FFFC;

    typedef enum logic [SEL_W-1:0] {
        SEL_HEAD = 3'd0,
        SEL_DONE = 3'd1,
        SEL_STOP = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_SRST = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_READ,
        WK_START,
        WK_WAIT,
        WK_BACK
    } walk_state_e;

    typedef struct packed {
        logic              done;
        logic              halt;
        logic              stop;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] link;
    } walk_evt_t;

    function automatic logic [WORD_W-1:0] retire_mode(
        input logic [WORD_W-1:0] mode,
        input logic              last,
        input logic              torn
    );
        logic [WORD_W-1:0] r;
        r          = mode;
        r[OWN_BIT] = 1'b0;
        if (last) r[EOQ_BIT] = 1'b1;
        if (torn) r[TDC_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int CHAN_ID     = 0,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  walk_evt_t         evt,
    output logic [WORD_W-1:0] head_ptr,
    output logic [WORD_W-1:0] done_ptr,
    output logic              enable,
    output logic              stop_req,
    output logic              irq,
    output logic              srst_start,
    output logic              srst_busy
);

    localparam int CNT_W = $clog2(SRST_CYCLES + 1);

    logic [CNT_W-1:0]  srst_cnt;
    logic [WORD_W-1:0] last_ptr;

    logic wr_head, wr_done, wr_stop, wr_ctrl;

    assign srst_busy  = (srst_cnt != '0);
    assign srst_start = reg_wr && (reg_sel == SEL_SRST) && reg_wdata[0] && !srst_busy;

    assign wr_head = reg_wr && (reg_sel == SEL_HEAD) && !busy && !stop_req;
    assign wr_done = reg_wr && (reg_sel == SEL_DONE);
    assign wr_stop = reg_wr && (reg_sel == SEL_STOP) && (reg_wdata == WORD_W'(CHAN_ID));
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst || srst_start) begin
            head_ptr <= '0;
            done_ptr <= '0;
            last_ptr <= '0;
            enable   <= 1'b0;
            stop_req <= 1'b0;
            irq      <= 1'b0;
            srst_cnt <= rst ? '0 : CNT_W'(SRST_CYCLES);
        end else if (srst_busy) begin
            srst_cnt <= srst_cnt - 1'b1;
        end else begin
            // software writes first, engine events take precedence
            if (wr_head) head_ptr <= reg_wdata;
            if (wr_done) begin
                done_ptr <= reg_wdata;
                if (reg_wdata == last_ptr) irq <= 1'b0;
            end
            if (wr_stop) stop_req <= 1'b1;
            if (wr_ctrl) enable   <= reg_wdata[0];

            if (evt.halt) head_ptr <= '0;
            if (evt.done) begin
                head_ptr <= evt.link;
                done_ptr <= evt.addr;
                last_ptr <= evt.addr;
                irq      <= 1'b1;
            end
            if (evt.stop) begin
                head_ptr <= '0;
                done_ptr <= STOP_MARK;
                last_ptr <= STOP_MARK;
                irq      <= 1'b1;
                stop_req <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_HEAD: reg_rdata = head_ptr;
            SEL_DONE: reg_rdata = done_ptr;
            SEL_CTRL: reg_rdata = {{(WORD_W-1){1'b0}}, enable};
            SEL_SRST: reg_rdata = {{(WORD_W-1){1'b0}}, srst_busy};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmach_walker.sv
module dmach_walker
    import dmach_pkg::*;
#(
    parameter int DESC_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] head_ptr,
    input  logic              enable,
    input  logic              stop_req,
    output logic              busy,
    output walk_evt_t         evt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mv_req,
    output logic [WORD_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    input  logic              mv_done
);

    localparam int IDX_W    = $clog2(DESC_WORDS);
    localparam int LINK_IX  = 0;
    localparam int BUF_IX   = 1;
    localparam int LEN_IX   = 2;
    localparam int MODE_IX  = DESC_WORDS - 1;
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(MODE_IX);

    walk_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] words_q [DESC_WORDS];

    logic last_read;
    assign last_read = (state == WK_READ) && mem_ready && (idx == LAST_IX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WK_IDLE;
            idx   <= '0;
            cur   <= '0;
            for (int i = 0; i < DESC_WORDS; i++) words_q[i] <= '0;
        end else begin
            case (state)
                WK_IDLE: begin
                    if (!stop_req && enable && (head_ptr != '0)) begin
                        cur   <= head_ptr;
                        idx   <= '0;
                        state <= WK_READ;
                    end
                end
                WK_READ: begin
                    if (mem_ready) begin
                        words_q[idx] <= mem_rdata;
                        if (idx == LAST_IX)
                            state <= mem_rdata[OWN_BIT] ? WK_START : WK_IDLE;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                WK_START: state <= WK_WAIT;
                WK_WAIT:  if (mv_done) state <= WK_BACK;
                WK_BACK:  if (mem_ready) state <= WK_IDLE;
                default:  state <= WK_IDLE;
            endcase
        end
    end

    assign busy      = (state != WK_IDLE);
    assign mem_valid = (state == WK_READ) || (state == WK_BACK);
    assign mem_we    = (state == WK_BACK);
    assign mem_addr  = cur + ((state == WK_BACK) ? WORD_W'(MODE_IX * 4)
                                                 : WORD_W'({idx, 2'b00}));
    assign mem_wdata = retire_mode(words_q[MODE_IX], words_q[LINK_IX] == '0, stop_req);

    assign mv_req  = (state == WK_START);
    assign mv_addr = words_q[BUF_IX];
    assign mv_len  = words_q[LEN_IX][LEN_W-1:0];

    always_comb begin
        evt.done = (state == WK_BACK) && mem_ready;
        evt.halt = last_read && !mem_rdata[OWN_BIT];
        evt.stop = stop_req && (((state == WK_BACK) && mem_ready) || (state == WK_IDLE));
        evt.addr = cur;
        evt.link = words_q[LINK_IX];
    end

endmodule

// File: rtl/dma_txchan_engine.sv
module dma_txchan_engine
    import dmach_pkg::*;
#(
    parameter int CHAN_ID     = 0,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              mv_req,
    output logic [31:0]       mv_addr,
    output logic [10:0]       mv_len,
    input  logic              mv_done,
    output logic              irq
);

    logic [WORD_W-1:0] head_ptr;
    logic [WORD_W-1:0] done_ptr;
    logic              enable;
    logic              stop_req;
    logic              busy;
    logic              srst_start;
    logic              srst_busy;
    logic              walk_rst;
    walk_evt_t         evt;

    logic              evt_done;
    logic              evt_stop;
    logic [WORD_W-1:0] evt_addr;

    assign walk_rst = rst || srst_start || srst_busy;
    assign evt_done = evt.done;
    assign evt_stop = evt.stop;
    assign evt_addr = evt.addr;

    dmach_regs #(
        .CHAN_ID     (CHAN_ID),
        .SRST_CYCLES (SRST_CYCLES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .evt        (evt),
        .head_ptr   (head_ptr),
        .done_ptr   (done_ptr),
        .enable     (enable),
        .stop_req   (stop_req),
        .irq        (irq),
        .srst_start (srst_start),
        .srst_busy  (srst_busy)
    );

    dmach_walker #(
        .DESC_WORDS (4)
    ) u_walker (
        .clk       (clk),
        .rst       (walk_rst),
        .head_ptr  (head_ptr),
        .enable    (enable),
        .stop_req  (stop_req),
        .busy      (busy),
        .evt       (evt),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mv_req    (mv_req),
        .mv_addr   (mv_addr),
        .mv_len    (mv_len),
        .mv_done   (mv_done)
    );

endmodule

// File: rtl/dmach_checker.sv
module dmach_checker
    import dmach_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mv_req,
    input logic              busy,
    input logic              enable,
    input logic              evt_done,
    input logic              evt_stop,
    input logic [WORD_W-1:0] evt_addr,
    input logic [WORD_W-1:0] done_ptr,
    input logic              irq,
    input logic              srst_busy
);

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            ((mem_valid && $stable(mem_addr) && $stable(mem_we)) || srst_busy)); // R14

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        mv_req |=> !mv_req); // R3

    AST_FETCH_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(enable)); // R10

    AST_STOP_SENTINEL: assert property (@(posedge clk) disable iff (rst)
        evt_stop |=> ((done_ptr == STOP_MARK && irq) || srst_busy)); // R11

    AST_DONE_POINTER: assert property (@(posedge clk) disable iff (rst)
        (evt_done && !evt_stop) |=> ((done_ptr == $past(evt_addr) && irq) || srst_busy)); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_done || evt_stop)); // R6

    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        srst_busy |-> (!mem_valid && !mv_req)); // R13

endmodule

bind dma_txchan_engine dmach_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mv_req    (mv_req),
    .busy      (busy),
    .enable    (enable),
    .evt_done  (evt_done),
    .evt_stop  (evt_stop),
    .evt_addr  (evt_addr),
    .done_ptr  (done_ptr),
    .irq       (irq),
    .srst_busy (srst_busy)
);

// File: tb/tb_dma_txchan_engine.sv
module tb_dma_txchan_engine;

    localparam int CHAN   = 0;
    localparam int SRSTN  = 4;
    localparam logic [31:0] SOP  = 32'h8000_0000;
    localparam logic [31:0] EOP  = 32'h4000_0000;
    localparam logic [31:0] OWN  = 32'h2000_0000;
    localparam logic [31:0] EOQ  = 32'h1000_0000;
    localparam logic [31:0] TDC  = 32'h0800_0000;
    localparam logic [31:0] MARK = 32'hFFFF_FFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        mv_req;
    logic [31:0] mv_addr;
    logic [10:0] mv_len;
    logic        mv_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [0:127];
    logic [31:0] rd_log [0:63];
    int          rd_n = 0;
    int          wr_n = 0;
    logic [31:0] mv_alog [0:15];
    logic [10:0] mv_llog [0:15];
    int          mv_n = 0;
    int          mv_wait = 0;
    logic        rdy_tog = 1'b0;

    always #10 clk = ~clk;

    dma_txchan_engine #(.CHAN_ID(CHAN), .SRST_CYCLES(SRSTN)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len),
        .mv_done(mv_done), .irq(irq)
    );

    // descriptor memory: accepts every other cycle
    assign mem_rdata = mem[mem_addr[8:2]];

    always @(negedge clk) begin
        rdy_tog   <= ~rdy_tog;
        mem_ready <= rdy_tog;
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[8:2]] <= mem_wdata;
                wr_n <= wr_n + 1;
            end else begin
                rd_log[rd_n % 64] <= mem_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    // data mover stub: done three cycles after the start pulse
    always @(negedge clk) begin
        mv_done <= 1'b0;
        if (mv_req) begin
            mv_alog[mv_n % 16] <= mv_addr;
            mv_llog[mv_n % 16] <= mv_len;
            mv_n    <= mv_n + 1;
            mv_wait <= 3;
        end else if (mv_wait != 0) begin
            mv_wait <= mv_wait - 1;
            if (mv_wait == 1) mv_done <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_desc(input int a, input logic [31:0] link, input logic [31:0] bp,
                            input logic [31:0] len, input bit owned);
        mem[a/4]     = link;
        mem[a/4 + 1] = bp;
        mem[a/4 + 2] = len;
        mem[a/4 + 3] = SOP | EOP | (owned ? OWN : 32'd0) | (len & 32'h7FF);
    endtask

    task automatic wait_writes(input int target);
        for (int i = 0; i < 400 && wr_n < target; i++) @(negedge clk);
        idle(3);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(3'd0, v); chk("R1 head after reset", v, 0);
        reg_read(3'd1, v); chk("R1 completion after reset", v, 0);
        reg_read(3'd3, v); chk("R1 control after reset", v, 0);
        reg_read(3'd4, v); chk("R1 soft reset after reset", v, 0);
        chk("R1 irq after reset", {31'd0, irq}, 0);
    endtask

    task automatic t_single;
        logic [31:0] v;
        int rb = rd_n, mb = mv_n, wb = wr_n;
        set_desc(32'h40, 0, 32'h0000_1000, 32'h5A, 1'b1);
        reg_write(3'd3, 1);
        reg_write(3'd0, 32'h40);
        wait_writes(wb + 1);
        chk("R2 read order word0", rd_log[rb],     32'h40);
        chk("R2 read order word1", rd_log[rb + 1], 32'h44);
        chk("R2 read order word2", rd_log[rb + 2], 32'h48);
        chk("R2 read order word3", rd_log[rb + 3], 32'h4C);
        chk("R3 one start pulse", mv_n - mb, 1);
        chk("R3 mover address", mv_alog[mb % 16], 32'h1000);
        chk("R3 mover length", {21'd0, mv_llog[mb % 16]}, 32'h5A);
        chk("R4 R5 written back mode", mem[32'h4C/4], SOP | EOP | EOQ | 32'h5A);
        reg_read(3'd1, v); chk("R6 completion pointer", v, 32'h40);
        chk("R6 irq set", {31'd0, irq}, 1);
        reg_read(3'd0, v); chk("R5 head zero at end", v, 0);
        reg_write(3'd1, 32'h44);
        chk("R7 irq held on wrong ack", {31'd0, irq}, 1);
        reg_write(3'd1, 32'h40);
        chk("R7 irq cleared on matching ack", {31'd0, irq}, 0);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        int mb = mv_n, wb = wr_n;
        set_desc(32'h80, 32'h90, 32'h2000, 32'd64, 1'b1);
        set_desc(32'h90, 32'hA0, 32'h2100, 32'd65, 1'b1);
        set_desc(32'hA0, 0,      32'h2200, 32'd66, 1'b1);
        set_desc(32'hC0, 0,      32'h2300, 32'd67, 1'b1);
        reg_write(3'd0, 32'h80);
        idle(4);
        reg_write(3'd0, 32'hC0);
        wait_writes(wb + 3);
        chk("R8 busy head write ignored, count", mv_n - mb, 3);
        chk("R5 chain second buffer", mv_alog[(mb + 1) % 16], 32'h2100);
        chk("R5 chain third buffer", mv_alog[(mb + 2) % 16], 32'h2200);
        chk("R4 R5 first mode no EOQ", mem[32'h8C/4], SOP | EOP | 32'd64);
        chk("R4 R5 last mode EOQ", mem[32'hAC/4], SOP | EOP | EOQ | 32'd66);
        reg_read(3'd1, v); chk("R6 completion after chain", v, 32'hA0);
        reg_read(3'd0, v); chk("R8 head zero after chain", v, 0);
        reg_write(3'd1, 32'hA0);
        reg_write(3'd0, 32'hC0);
        wait_writes(wb + 4);
        chk("R5 resume on new head", mv_alog[(mb + 3) % 16], 32'h2300);
        reg_write(3'd1, 32'hC0);
        chk("R7 ack after resume", {31'd0, irq}, 0);
    endtask

    task automatic t_not_owned;
        logic [31:0] v;
        int mb = mv_n, wb = wr_n;
        set_desc(32'hC0, 0, 32'h2400, 32'd70, 1'b0);
        reg_write(3'd0, 32'hC0);
        idle(20);
        chk("R9 no mover request", mv_n - mb, 0);
        chk("R9 no write-back", wr_n - wb, 0);
        reg_read(3'd0, v); chk("R9 head cleared", v, 0);
        chk("R9 irq unchanged", {31'd0, irq}, 0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        int mb = mv_n;
        set_desc(32'hD0, 32'hE0, 32'h3000, 32'd80, 1'b1);
        set_desc(32'hE0, 0,      32'h3100, 32'd81, 1'b1);
        reg_write(3'd0, 32'hD0);
        for (int i = 0; i < 100 && mv_n == mb; i++) @(negedge clk);
        reg_write(3'd3, 0);
        idle(30);
        chk("R10 in-flight completes only", mv_n - mb, 1);
        reg_read(3'd0, v); chk("R10 head holds link", v, 32'hE0);
        chk("R10 first written back", mem[32'hDC/4], SOP | EOP | 32'd80);
        reg_write(3'd3, 1);
        idle(30);
        chk("R10 resumes", mv_n - mb, 2);
        reg_write(3'd1, 32'hE0);
    endtask

    task automatic t_teardown_busy;
        logic [31:0] v;
        int mb = mv_n;
        set_desc(32'h100, 32'h110, 32'h4000, 32'd90, 1'b1);
        set_desc(32'h110, 0,       32'h4100, 32'd91, 1'b1);
        reg_write(3'd0, 32'h100);
        for (int i = 0; i < 100 && mv_n == mb; i++) @(negedge clk);
        reg_write(3'd2, CHAN);
        idle(30);
        chk("R11 only in-flight moved", mv_n - mb, 1);
        chk("R11 teardown bit in mode", mem[32'h10C/4], SOP | EOP | TDC | 32'd90);
        chk("R11 rest untouched", mem[32'h11C/4], SOP | EOP | OWN | 32'd91);
        reg_read(3'd1, v); chk("R11 sentinel", v, MARK);
        reg_read(3'd0, v); chk("R11 head cleared", v, 0);
        chk("R11 irq", {31'd0, irq}, 1);
        reg_write(3'd1, MARK);
        chk("R7 sentinel ack clears irq", {31'd0, irq}, 0);
    endtask

    task automatic t_teardown_idle;
        logic [31:0] v;
        int wb = wr_n;
        reg_write(3'd1, 0);
        reg_write(3'd2, CHAN + 1);
        idle(5);
        reg_read(3'd1, v); chk("R12 wrong channel ignored", v, 0);
        chk("R12 wrong channel no irq", {31'd0, irq}, 0);
        reg_write(3'd2, CHAN);
        idle(3);
        reg_read(3'd1, v); chk("R12 idle sentinel", v, MARK);
        chk("R12 idle irq", {31'd0, irq}, 1);
        chk("R12 no memory write", wr_n - wb, 0);
    endtask

    task automatic t_soft_reset;
        logic [31:0] v;
        reg_write(3'd4, 1);
        reg_read(3'd4, v); chk("R13 reads 1 while running", v, 1);
        idle(SRSTN + 2);
        reg_read(3'd4, v); chk("R13 reads 0 when done", v, 0);
        reg_read(3'd3, v); chk("R13 control cleared", v, 0);
        reg_read(3'd1, v); chk("R13 completion cleared", v, 0);
        reg_read(3'd0, v); chk("R13 head cleared", v, 0);
        chk("R13 irq cleared", {31'd0, irq}, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_not_owned();
        t_enable();
        t_teardown_busy();
        t_teardown_idle();
        t_soft_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule